// File: doc/BRIEF.md
# Vector Configuration Legality Checker

This unit holds the architectural vector type and vector length state and updates it from a configuration request. A request gives an element-width code, a register-grouping code, two policy bits, a reserved field and an application vector length. On a one-cycle valid pulse the unit decides whether the combination is supported. The decision uses two build-time parameters: `ELEN`, the widest element width, and `VLEN`, the width of one vector register.

For a supported request the unit stores the fields and sets the vector length to the smaller of the requested length and the maximum the grouping allows. For an unsupported request it raises the illegal flag and clears the length and every type field.

Fractional grouping is judged in two steps. The first step compares it with the narrowest element width (8 bits) relative to `ELEN`, not with the active width. The second step makes sure the fractional slice of a register still holds at least one element of the active width.

Top module: `vcfg_legal_unit`

## Requirements
- R1: While reset is asserted and right after it, `illegal_o` is 1, `vl_o` is 0 and all type fields are 0.
- R2: A request with `req_valid_i` high is reflected at the outputs in the cycle after the pulse. With `req_valid_i` low, the outputs keep their values whatever the other inputs carry.
- R3: Grouping code 4 always makes the request illegal. Grouping codes 0, 1, 2 and 3 mean factors 1, 2, 4 and 8. Codes 5, 6 and 7 mean 1/8, 1/4 and 1/2.
- R4: A fractional grouping code c is refused unless `ELEN >> (8-c)` is at least 8, whatever the active width. With ELEN=32 this accepts only 1/2 and 1/4. With ELEN=64 it accepts 1/2, 1/4 and 1/8.
- R5: Width codes 0..3 mean 8, 16, 32 and 64 bits. A width code of 4..7, a width larger than `ELEN`, or any nonzero bit in `req_rsvd_i` makes the request illegal.
- R6: A request whose element width exceeds `VLEN` times the grouping factor is illegal. For example, VLEN=64 with width 16 and factor 1/8 is refused. VLEN=128, ELEN=64, width 16, factor 1/8 is accepted.
- R7: For a legal request, `vl_o` = min(`req_avl_i`, VLEN*factor/width).
- R8: For an illegal request, `vl_o` is 0 and the width code, grouping code and both policy bits read 0.
- R9: For a legal request, the width code, grouping code and both policy bits read back exactly as requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | One-cycle configuration request strobe |
| req_sew_i | input | 3 | Requested element-width code |
| req_lmul_i | input | 3 | Requested register-grouping code |
| req_tail_agn_i | input | 1 | Tail policy bit, passed through |
| req_mask_agn_i | input | 1 | Mask policy bit, passed through |
| req_rsvd_i | input | RSVD_W | Reserved bits, must be zero |
| req_avl_i | input | AVL_W | Application vector length |
| cur_sew_o | output | 3 | Current element-width code |
| cur_lmul_o | output | 3 | Current grouping code |
| cur_tail_agn_o | output | 1 | Current tail policy bit |
| cur_mask_agn_o | output | 1 | Current mask policy bit |
| illegal_o | output | 1 | Current configuration is unsupported |
| vl_o | output | $clog2(VLEN)+1 | Current vector length |

## Verification
The state sits in a single register stage. A wrong legality decision or a wrong length shows up on `illegal_o`, `vl_o` or the type fields exactly one cycle after the request pulse, and stays visible until the next pulse. The bench sweeps every width and grouping code with reserved bits clear and set and with several lengths. It runs this on three parameter sets, so a corrupted decode yields a wrong flag or length on the very next cycle. Holding the strobe low while the fields change exposes any register that loads without a request.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  localparam int SEW_MIN_LOG = 3;  // narrowest element is 8 bits

  typedef logic signed [7:0] log2_t;

  typedef struct packed {
    logic        sew_bad;
    logic        lmul_bad;
    logic        frac;
    logic [1:0]  frac_shift;
    log2_t       sew_log;
    log2_t       lmul_log;
  } vcfg_dec_t;
endpackage

// File: rtl/vcfg_field_dec.sv
module vcfg_field_dec
  import vcfg_pkg::*;
(
  input  logic [2:0] sew_code_i,
  input  logic [2:0] lmul_code_i,
  output vcfg_dec_t  dec_o
);
  logic [1:0] shift;

  // 8 - code for fractional codes 5..7
  assign shift = ~lmul_code_i[1:0] + 2'd1;

  always_comb begin
    dec_o            = '0;
    dec_o.sew_bad    = sew_code_i[2];
    dec_o.sew_log    = log2_t'(SEW_MIN_LOG) + log2_t'({6'd0, sew_code_i[1:0]});
    dec_o.frac       = lmul_code_i[2];
    dec_o.lmul_bad   = (lmul_code_i == 3'd4);
    if (lmul_code_i[2]) begin
      dec_o.frac_shift = shift;
      dec_o.lmul_log   = -log2_t'({6'd0, shift});
    end else begin
      dec_o.frac_shift = 2'd0;
      dec_o.lmul_log   = log2_t'({6'd0, lmul_code_i[1:0]});
    end
  end
endmodule

// File: rtl/vcfg_legal.sv
module vcfg_legal
  import vcfg_pkg::*;
#(
  parameter int ELEN = 64,
  parameter int VLEN = 128
) (
  input  vcfg_dec_t dec_i,
  input  logic      rsvd_nz_i,
  output logic      illegal_o
);
  localparam int LOG_ELEN = $clog2(ELEN);
  localparam int LOG_VLEN = $clog2(VLEN);

  logic sew_wide, frac_short, slice_short;

  assign sew_wide    = dec_i.sew_log > log2_t'(LOG_ELEN);
  // fractional factor judged against the narrowest width, not the active one
  assign frac_short  = dec_i.frac &&
                       ((log2_t'(LOG_ELEN) - log2_t'({6'd0, dec_i.frac_shift})) < log2_t'(SEW_MIN_LOG));
  // slice of VLEN*factor must hold one active element
  assign slice_short = (log2_t'(LOG_VLEN) + dec_i.lmul_log) < dec_i.sew_log;

  assign illegal_o = dec_i.sew_bad | dec_i.lmul_bad | rsvd_nz_i |
                     sew_wide | frac_short | slice_short;
endmodule

// File: rtl/vcfg_vlen_calc.sv
module vcfg_vlen_calc
  import vcfg_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int AVL_W = 16
) (
  input  vcfg_dec_t                  dec_i,
  input  logic [AVL_W-1:0]           avl_i,
  output logic [$clog2(VLEN):0]      vl_o
);
  localparam int LOG_VLEN = $clog2(VLEN);
  localparam int VL_W     = LOG_VLEN + 1;

  log2_t           vlmax_log;
  logic [VL_W-1:0] vlmax;

  assign vlmax_log = log2_t'(LOG_VLEN) + dec_i.lmul_log - dec_i.sew_log;
  assign vlmax     = vlmax_log[7] ? '0 : (VL_W'(1) << vlmax_log[6:0]);

  generate
    if (AVL_W > VL_W) begin : g_wide_avl
      assign vl_o = (avl_i >= AVL_W'(vlmax)) ? vlmax : avl_i[VL_W-1:0];
    end else begin : g_narrow_avl
      assign vl_o = (VL_W'(avl_i) >= vlmax) ? vlmax : VL_W'(avl_i);
    end
  endgenerate
endmodule

// File: rtl/vcfg_legal_unit.sv
module vcfg_legal_unit
  import vcfg_pkg::*;
#(
  parameter int ELEN   = 64,
  parameter int VLEN   = 128,
  parameter int AVL_W  = 16,
  parameter int RSVD_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic [2:0]             req_sew_i,
  input  logic [2:0]             req_lmul_i,
  input  logic                   req_tail_agn_i,
  input  logic                   req_mask_agn_i,
  input  logic [RSVD_W-1:0]      req_rsvd_i,
  input  logic [AVL_W-1:0]       req_avl_i,
  output logic [2:0]             cur_sew_o,
  output logic [2:0]             cur_lmul_o,
  output logic                   cur_tail_agn_o,
  output logic                   cur_mask_agn_o,
  output logic                   illegal_o,
  output logic [$clog2(VLEN):0]  vl_o
);
  localparam int VL_W = $clog2(VLEN) + 1;

  vcfg_dec_t       dec;
  logic            bad;
  logic [VL_W-1:0] vl_new;

  vcfg_field_dec u_dec (
    .sew_code_i  (req_sew_i),
    .lmul_code_i (req_lmul_i),
    .dec_o       (dec)
  );

  vcfg_legal #(.ELEN(ELEN), .VLEN(VLEN)) u_legal (
    .dec_i     (dec),
    .rsvd_nz_i (|req_rsvd_i),
    .illegal_o (bad)
  );

  vcfg_vlen_calc #(.VLEN(VLEN), .AVL_W(AVL_W)) u_vl (
    .dec_i (dec),
    .avl_i (req_avl_i),
    .vl_o  (vl_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_sew_o      <= '0;
      cur_lmul_o     <= '0;
      cur_tail_agn_o <= 1'b0;
      cur_mask_agn_o <= 1'b0;
      illegal_o      <= 1'b1;
      vl_o           <= '0;
    end else if (req_valid_i) begin
      illegal_o <= bad;
      if (bad) begin
        cur_sew_o      <= '0;
        cur_lmul_o     <= '0;
        cur_tail_agn_o <= 1'b0;
        cur_mask_agn_o <= 1'b0;
        vl_o           <= '0;
      end else begin
        cur_sew_o      <= req_sew_i;
        cur_lmul_o     <= req_lmul_i;
        cur_tail_agn_o <= req_tail_agn_i;
        cur_mask_agn_o <= req_mask_agn_i;
        vl_o           <= vl_new;
      end
    end
  end
endmodule

// File: rtl/vcfg_legal_unit_chk.sv
module vcfg_legal_unit_chk #(
  parameter int ELEN   = 64,
  parameter int VLEN   = 128,
  parameter int AVL_W  = 16,
  parameter int RSVD_W = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic [2:0]            req_sew_i,
  input logic [2:0]            req_lmul_i,
  input logic [RSVD_W-1:0]     req_rsvd_i,
  input logic [AVL_W-1:0]      req_avl_i,
  input logic [2:0]            cur_sew_o,
  input logic [2:0]            cur_lmul_o,
  input logic                  cur_tail_agn_o,
  input logic                  cur_mask_agn_o,
  input logic                  illegal_o,
  input logic [$clog2(VLEN):0] vl_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_reset_state_r1: assert (illegal_o && vl_o == '0 && cur_sew_o == '0 && cur_lmul_o == '0);
    end
  end

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(vl_o) && $stable(illegal_o) && $stable(cur_sew_o) && $stable(cur_lmul_o)));

  p_lmul_rsvd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_lmul_i == 3'd4) |=> illegal_o);

  p_frac_min_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_lmul_i[2] && ((ELEN >> (4'd8 - {1'b0, req_lmul_i})) < 8)) |=> illegal_o);

  p_rsvd_bits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (|req_rsvd_i || req_sew_i[2])) |=> illegal_o);

  p_vl_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> ({{(AVL_W){1'b0}}, vl_o} <= {{($clog2(VLEN)+1){1'b0}}, $past(req_avl_i)}));

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (vl_o == '0 && cur_sew_o == '0 && cur_lmul_o == '0 && !cur_tail_agn_o && !cur_mask_agn_o));
endmodule

bind vcfg_legal_unit vcfg_legal_unit_chk #(
  .ELEN(ELEN), .VLEN(VLEN), .AVL_W(AVL_W), .RSVD_W(RSVD_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_sew_i      (req_sew_i),
  .req_lmul_i     (req_lmul_i),
  .req_rsvd_i     (req_rsvd_i),
  .req_avl_i      (req_avl_i),
  .cur_sew_o      (cur_sew_o),
  .cur_lmul_o     (cur_lmul_o),
  .cur_tail_agn_o (cur_tail_agn_o),
  .cur_mask_agn_o (cur_mask_agn_o),
  .illegal_o      (illegal_o),
  .vl_o           (vl_o)
);

// File: tb/vcfg_legal_unit_bench.sv
`timescale 1ns/1ps
module vcfg_legal_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [2:0] sew = '0, lmul = '0;
  logic       ta = 1'b0, ma = 1'b0;
  logic [7:0] rsvd = '0;
  logic [15:0] avl = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // three configurations: {ELEN,VLEN} = {64,128}, {64,64}, {32,128}
  logic [2:0] s_a, l_a, s_b, l_b, s_c, l_c;
  logic ta_a, ma_a, ta_b, ma_b, ta_c, ma_c, il_a, il_b, il_c;
  logic [7:0] vl_a;
  logic [6:0] vl_b;
  logic [7:0] vl_c;

  vcfg_legal_unit #(.ELEN(64), .VLEN(128)) u_vcfg_legal_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_sew_i(sew), .req_lmul_i(lmul),
    .req_tail_agn_i(ta), .req_mask_agn_i(ma), .req_rsvd_i(rsvd), .req_avl_i(avl),
    .cur_sew_o(s_a), .cur_lmul_o(l_a), .cur_tail_agn_o(ta_a), .cur_mask_agn_o(ma_a),
    .illegal_o(il_a), .vl_o(vl_a));

  vcfg_legal_unit #(.ELEN(64), .VLEN(64)) u_vcfg_legal_unit_v64 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_sew_i(sew), .req_lmul_i(lmul),
    .req_tail_agn_i(ta), .req_mask_agn_i(ma), .req_rsvd_i(rsvd), .req_avl_i(avl),
    .cur_sew_o(s_b), .cur_lmul_o(l_b), .cur_tail_agn_o(ta_b), .cur_mask_agn_o(ma_b),
    .illegal_o(il_b), .vl_o(vl_b));

  vcfg_legal_unit #(.ELEN(32), .VLEN(128)) u_vcfg_legal_unit_e32 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_sew_i(sew), .req_lmul_i(lmul),
    .req_tail_agn_i(ta), .req_mask_agn_i(ma), .req_rsvd_i(rsvd), .req_avl_i(avl),
    .cur_sew_o(s_c), .cur_lmul_o(l_c), .cur_tail_agn_o(ta_c), .cur_mask_agn_o(ma_c),
    .illegal_o(il_c), .vl_o(vl_c));

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // arithmetic model: factor = num/den, legality from the requirement text
  task automatic model(input int elen, input int vlen, input int sc, input int lc,
                       input int rs, input int av, output bit ill, output int vl);
    int w, num, den, vmax;
    ill = 1'b0;
    w = 8 << (sc & 3);
    if (sc > 3) ill = 1'b1;                       // R5
    if (w > elen) ill = 1'b1;                     // R5
    if (rs != 0) ill = 1'b1;                      // R5
    if (lc == 4) ill = 1'b1;                      // R3
    if (lc < 4) begin num = 1 << lc; den = 1; end
    else begin num = 1; den = 1 << (8 - lc); end
    if (lc > 4 && elen < 8 * den) ill = 1'b1;     // R4
    if (vlen * num < w * den) ill = 1'b1;         // R6
    vmax = (vlen * num) / (w * den);
    vl = ill ? 0 : ((av < vmax) ? av : vmax);     // R7, R8
  endtask

  task automatic check_one(input string tag, input int elen, input int vlen,
                           input int sc, input int lc, input int rs, input int av,
                           input bit t, input bit m,
                           input bit il, input int vl, input int so, input int lo,
                           input bit tao, input bit mao);
    bit eil; int evl;
    model(elen, vlen, sc, lc, rs, av, eil, evl);
    chk(il == eil, $sformatf("R3/R4/R5/R6 %s illegal sew=%0d lmul=%0d rsvd=%0d", tag, sc, lc, rs), il, eil);
    chk(vl == evl, $sformatf("R7/R8 %s vl sew=%0d lmul=%0d avl=%0d", tag, sc, lc, av), vl, evl);
    if (eil)
      chk(so == 0 && lo == 0 && !tao && !mao, $sformatf("R8 %s fields cleared", tag),
          so * 64 + lo * 4 + tao * 2 + mao, 0);
    else
      chk(so == sc && lo == lc && tao == t && mao == m, $sformatf("R9 %s fields", tag),
          so * 64 + lo * 4 + tao * 2 + mao, sc * 64 + lc * 4 + t * 2 + m);
  endtask

  task automatic check_all(input int sc, input int lc, input int rs, input int av,
                           input bit t, input bit m);
    check_one("e64v128", 64, 128, sc, lc, rs, av, t, m, il_a, int'(vl_a), s_a, l_a, ta_a, ma_a);
    check_one("e64v64",  64, 64,  sc, lc, rs, av, t, m, il_b, int'(vl_b), s_b, l_b, ta_b, ma_b);
    check_one("e32v128", 32, 128, sc, lc, rs, av, t, m, il_c, int'(vl_c), s_c, l_c, ta_c, ma_c);
  endtask

  initial begin : main
    int avls[4];
    avls[0] = 0; avls[1] = 1; avls[2] = 5; avls[3] = 1000;
    repeat (3) @(negedge clk);
    // R1: reset state, during reset
    chk(il_a && vl_a == 0 && s_a == 0 && l_a == 0 && !ta_a && !ma_a, "R1 reset state", int'(vl_a), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(il_b && vl_b == 0 && il_c && vl_c == 0, "R1 after release", int'(il_b), 1);

    for (int sc = 0; sc < 8; sc++) begin
      for (int lc = 0; lc < 8; lc++) begin
        for (int rs = 0; rs < 2; rs++) begin
          for (int ai = 0; ai < 4; ai++) begin
            bit t, m;
            t = bit'(sc ^ lc);
            m = bit'(ai);
            sew = 3'(sc); lmul = 3'(lc); rsvd = 8'(rs << 5); avl = 16'(avls[ai]);
            ta = t; ma = m; valid = 1'b1;
            @(negedge clk);
            valid = 1'b0;
            // R2: visible one cycle after the pulse
            check_all(sc, lc, rs, avls[ai], t, m);
            // R2: no strobe, scrambled fields, state must not move
            sew = ~sew; lmul = 3'd4; rsvd = 8'hff; avl = 16'h0003; ta = ~t; ma = ~m;
            @(negedge clk);
            check_all(sc, lc, rs, avls[ai], t, m);
          end
        end
      end
    end

    // named corner cases
    sew = 3'd1; lmul = 3'd5; rsvd = '0; avl = 16'd50; ta = 1'b0; ma = 1'b0; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    chk(!il_a && vl_a == 1, "R6 e64 v128 w16 1/8 accepted", int'(il_a), 0);
    chk(il_b, "R6 e64 v64 w16 1/8 refused", int'(il_b), 1);
    sew = 3'd0; lmul = 3'd5; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    chk(il_c, "R4 e32 w8 1/8 refused despite wide VLEN", int'(il_c), 1);
    chk(!il_a && vl_a == 2, "R4 e64 w8 1/8 accepted", int'(vl_a), 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule